// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

The block gathers interrupt requests from 31 groups of four lines each and presents the processor with two things: a one-cycle pulse for the non-maskable groups (0 and 1), and a continuously driven 3-bit level that names the most urgent pending request among the maskable groups (2 to 30). Each maskable group carries its own priority level and a four-bit enable mask. Trigger detection is done outside the block: every request line arrives as a one-cycle set pulse.

A byte-wide register port reads and writes the group state. Each group owns four consecutive bytes, at address `group*4 + byte`. The register that holds the accepted group sits at address 124. When the processor takes a maskable interrupt, it acknowledges with the level it was given. The block then latches the group that was winning at that moment. Later reads of address 124 report that group, or zero if its request has been cleared in the meantime.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset:
  - `level_out` is 7.
  - Every request bit, every maskable enable and every level reads 0.
  - Address 124 reads 0.
  - `nmi_pulse` and `ack_error` are low.
- R2: Read and write of byte 0 of a maskable group:
  - A write is applied per line, with bits 7:4 as qualifiers and bits 3:0 as data.
  - Data 1 with qualifier 1 sets the request. Data 1 with qualifier 0 clears it. Data 0 leaves it unchanged.
  - A read returns the requests in bits 7:4 and requests AND enables in bits 3:0.
- R3: Byte 1 of a maskable group holds the level in bits 6:4 and the enable mask in bits 3:0. Bit 7 reads 0.
- R4: `level_out` is the smallest level among maskable groups that have at least one enabled pending request. It is 7 when there is none, so a group at level 7 never lowers it.
- R5: On equal levels the lowest-numbered group wins.
- R6: `level_out` is registered. It changes on the clock edge after the edge that updated a request, enable or level.
- R7: A pulse on `req_set[g*4+l]` sets request line l of group g. If a byte-0 write clears the same bit in the same cycle, the set wins.
- R8: Byte 0 of a non-maskable group:
  - A read returns the requests in bits 3:0 and 0 in bits 7:4.
  - Writing 1 to a bit of byte 0 clears that request.
  - Writing 1 to a bit of byte 3 sets that request.
  - The enables of these groups are fixed on.
- R9: `nmi_pulse` is high for exactly the cycle after a set event on a non-maskable group, either a line pulse or a byte-3 write with a nonzero low nibble. It is low otherwise.
- R10: When `ack_valid` is high, the group behind the current `level_out` is latched. Address 124 reads that group number shifted left by 2, or 0 if the group no longer has an enabled pending request.
- R11: Writes to address 124 change nothing.
- R12: `ack_error` is high in the cycle after an acknowledge whose `ack_level` differs from `level_out`, and low otherwise.
- R13: Requests in the non-maskable groups never affect `level_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set | input | 124 | One-cycle set pulse per request line, index group*4+line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| nmi_pulse | output | 1 | Non-maskable interrupt pulse |
| level_out | output | 3 | Level of the best pending maskable group, 7 when none |
| ack_error | output | 1 | Acknowledge level did not match `level_out` |

## Verification
The bench walks a sequence of register writes through the arbitration corners:
- Masking a pending line.
- Ties between two groups at the same level.
- A level-0 group pushed down to level 7.
- A hold write that should change nothing.

A wrong comparison or scan order would show up as a wrong level, or as the higher-numbered group being accepted. Requests that disappear after an acknowledge must make the accepted register read zero; a design that keeps reporting the stale group would return a nonzero value. The bench also aims at the same-cycle set-versus-clear race, byte-3 writes with empty data, and writes to the read-only address. Each of these would show up as a wrong readback or as a spurious or missing NMI pulse.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
    localparam int LINES  = 4;
    localparam int LVL_W  = 3;
    localparam int DATA_W = 8;

    typedef logic [LINES-1:0] line_vec_t;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/grp_irq_bank.sv
module grp_irq_bank
    import grp_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 31,
    parameter int NUM_NMI    = 2,
    parameter int ADDR_W     = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GROUPS*LINES-1:0]   req_set,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output line_vec_t [NUM_GROUPS-1:0]    req_q,
    output line_vec_t [NUM_GROUPS-1:0]    en_q,
    output lvl_t      [NUM_GROUPS-1:0]    lvl_q,
    output logic                          nmi_set
);
    typedef struct packed {
        line_vec_t [NUM_GROUPS-1:0] req;
        line_vec_t [NUM_GROUPS-1:0] en;
        lvl_t      [NUM_GROUPS-1:0] lvl;
    } bank_t;

    bank_t st_d, st_q;

    logic [ADDR_W-3:0] wr_gid;
    logic [1:0]        wr_byte;
    line_vec_t         wr_qual, wr_bits;

    assign wr_gid  = wr_addr[ADDR_W-1:2];
    assign wr_byte = wr_addr[1:0];
    assign wr_qual = wr_data[7:4];
    assign wr_bits = wr_data[3:0];

    always_comb begin
        st_d    = st_q;
        nmi_set = 1'b0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (g < NUM_NMI) begin
                // non-maskable: clear through byte 0, set through byte 3
                if (wr_en && int'(wr_gid) == g && wr_byte == 2'd0)
                    st_d.req[g] = st_d.req[g] & ~wr_bits;
                if (wr_en && int'(wr_gid) == g && wr_byte == 2'd3) begin
                    st_d.req[g] = st_d.req[g] | wr_bits;
                    nmi_set     = nmi_set | (|wr_bits);
                end
                st_d.req[g] = st_d.req[g] | req_set[g*LINES +: LINES];
                nmi_set     = nmi_set | (|req_set[g*LINES +: LINES]);
            end else begin
                if (wr_en && int'(wr_gid) == g && wr_byte == 2'd0)
                    st_d.req[g] = (wr_bits & wr_qual) | (~wr_bits & st_q.req[g]);
                if (wr_en && int'(wr_gid) == g && wr_byte == 2'd1) begin
                    st_d.lvl[g] = wr_data[6:4];
                    st_d.en[g]  = wr_bits;
                end
                // line pulses take precedence over a same-cycle clear
                st_d.req[g] = st_d.req[g] | req_set[g*LINES +: LINES];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int g = 0; g < NUM_NMI; g++)
                st_q.en[g] <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_q = st_q.req;
    assign en_q  = st_q.en;
    assign lvl_q = st_q.lvl;
endmodule

// File: rtl/grp_irq_arb.sv
module grp_irq_arb
    import grp_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 31,
    parameter int NUM_NMI    = 2,
    parameter int GID_W      = 5
) (
    input  line_vec_t [NUM_GROUPS-1:0] req,
    input  line_vec_t [NUM_GROUPS-1:0] en,
    input  lvl_t      [NUM_GROUPS-1:0] lvl,
    output logic [GID_W-1:0]           win_gid,
    output lvl_t                       win_lvl
);
    // Linear scan from the first maskable group; strict compare keeps the
    // lowest-numbered group on ties and leaves level-7 groups unselected.
    always_comb begin
        win_gid = '0;
        win_lvl = '1;
        for (int g = NUM_NMI; g < NUM_GROUPS; g++) begin
            if ((|(req[g] & en[g])) && (lvl[g] < win_lvl)) begin
                win_gid = GID_W'(g);
                win_lvl = lvl[g];
            end
        end
    end
endmodule

// File: rtl/grp_irq_rdmux.sv
module grp_irq_rdmux
    import grp_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 31,
    parameter int NUM_NMI    = 2,
    parameter int ADDR_W     = 7,
    parameter int GID_W      = 5
) (
    input  logic [ADDR_W-1:0]          addr,
    input  line_vec_t [NUM_GROUPS-1:0] req,
    input  line_vec_t [NUM_GROUPS-1:0] en,
    input  lvl_t      [NUM_GROUPS-1:0] lvl,
    input  logic [GID_W-1:0]           acc_gid,
    output logic [DATA_W-1:0]          rdata
);
    localparam int ACC_ADDR = NUM_GROUPS * LINES;

    logic [ADDR_W-3:0] gsel;
    assign gsel = addr[ADDR_W-1:2];

    always_comb begin
        rdata = '0;
        if (int'(addr) == ACC_ADDR) begin
            if (|(req[acc_gid] & en[acc_gid]))
                rdata = DATA_W'({acc_gid, 2'b00});
        end else if (int'(gsel) < NUM_GROUPS) begin
            if (int'(gsel) < NUM_NMI) begin
                if (addr[1:0] == 2'd0)
                    rdata = {4'b0, req[gsel]};
            end else begin
                case (addr[1:0])
                    2'd0:    rdata = {req[gsel], req[gsel] & en[gsel]};
                    2'd1:    rdata = {1'b0, lvl[gsel], en[gsel]};
                    default: rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
    import grp_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 31,
    parameter int NUM_NMI    = 2,
    localparam int ADDR_W    = $clog2(NUM_GROUPS*LINES + 1),
    localparam int GID_W     = $clog2(NUM_GROUPS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*LINES-1:0] req_set,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic                        ack_valid,
    input  logic [LVL_W-1:0]            ack_level,
    output logic                        nmi_pulse,
    output logic [LVL_W-1:0]            level_out,
    output logic                        ack_error
);
    typedef struct packed {
        lvl_t             level;
        logic [GID_W-1:0] winner;
        logic [GID_W-1:0] acc;
        logic             ack_err;
        logic             nmi;
    } ctl_t;

    line_vec_t [NUM_GROUPS-1:0] req, en;
    lvl_t      [NUM_GROUPS-1:0] lvl;
    logic                       nmi_set;
    logic [GID_W-1:0]           arb_gid;
    lvl_t                       arb_lvl;
    ctl_t                       ctl_d, ctl_q;

    grp_irq_bank #(
        .NUM_GROUPS(NUM_GROUPS), .NUM_NMI(NUM_NMI), .ADDR_W(ADDR_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .req_set(req_set),
        .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .req_q(req), .en_q(en), .lvl_q(lvl), .nmi_set(nmi_set)
    );

    grp_irq_arb #(
        .NUM_GROUPS(NUM_GROUPS), .NUM_NMI(NUM_NMI), .GID_W(GID_W)
    ) u_arb (
        .req(req), .en(en), .lvl(lvl), .win_gid(arb_gid), .win_lvl(arb_lvl)
    );

    grp_irq_rdmux #(
        .NUM_GROUPS(NUM_GROUPS), .NUM_NMI(NUM_NMI), .ADDR_W(ADDR_W), .GID_W(GID_W)
    ) u_rdmux (
        .addr(reg_addr), .req(req), .en(en), .lvl(lvl),
        .acc_gid(ctl_q.acc), .rdata(reg_rdata)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.level   = arb_lvl;
        ctl_d.winner  = arb_gid;
        ctl_d.nmi     = nmi_set;
        ctl_d.ack_err = ack_valid && (ack_level != ctl_q.level);
        if (ack_valid)
            ctl_d.acc = ctl_q.winner;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.level <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign level_out = ctl_q.level;
    assign nmi_pulse = ctl_q.nmi;
    assign ack_error = ctl_q.ack_err;
endmodule

// File: rtl/grp_irq_ctrl_chk.sv
module grp_irq_ctrl_chk
    import grp_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 31,
    parameter int NUM_NMI    = 2,
    localparam int ADDR_W    = $clog2(NUM_GROUPS*LINES + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_GROUPS*LINES-1:0] req_set,
    input logic                        reg_wr,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [DATA_W-1:0]           reg_wdata,
    input logic [DATA_W-1:0]           reg_rdata,
    input logic                        ack_valid,
    input logic [LVL_W-1:0]            ack_level,
    input logic                        nmi_pulse,
    input logic [LVL_W-1:0]            level_out,
    input logic                        ack_error
);
    localparam int ACC_ADDR = NUM_GROUPS * LINES;

    logic nmi_src;
    assign nmi_src = (|req_set[NUM_NMI*LINES-1:0]) ||
                     (reg_wr && int'(reg_addr[ADDR_W-1:2]) < NUM_NMI &&
                      reg_addr[1:0] == 2'd3 && (|reg_wdata[3:0]));

    assert_ack_mismatch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_level != level_out) |=> ack_error);

    assert_ack_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_valid && ack_level != level_out) |=> !ack_error);

    assert_nmi_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_src |=> nmi_pulse);

    assert_nmi_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_src |=> !nmi_pulse);

    assert_acc_format_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr) == ACC_ADDR) |->
            (reg_rdata[1:0] == 2'b00 && int'(reg_rdata[7:2]) < NUM_GROUPS &&
             int'(reg_rdata[7:2]) != 1));
endmodule

bind grp_irq_ctrl grp_irq_ctrl_chk #(.NUM_GROUPS(NUM_GROUPS), .NUM_NMI(NUM_NMI)) u_chk (.*);

// File: tb/grp_irq_ctrl_bench.sv
`timescale 1ns/1ps
module grp_irq_ctrl_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [123:0] req_set = '0;
    logic         reg_wr = 1'b0;
    logic [6:0]   reg_addr = '0;
    logic [7:0]   reg_wdata = '0;
    logic [7:0]   reg_rdata;
    logic         ack_valid = 1'b0;
    logic [2:0]   ack_level = '0;
    logic         nmi_pulse;
    logic [2:0]   level_out;
    logic         ack_error;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    grp_irq_ctrl u_grp_irq_ctrl (.*);

    typedef struct packed {
        logic [6:0] a;
        logic [7:0] d;
        logic [2:0] lv;
    } vec_t;

    localparam vec_t TBL [13] = '{
        '{7'd21,  8'h3F, 3'd7},  // g5 level 3, all enabled, nothing pending
        '{7'd20,  8'h11, 3'd3},  // set g5 line0
        '{7'd37,  8'h2F, 3'd3},  // g9 level 2, not pending
        '{7'd36,  8'h22, 3'd2},  // set g9 line1
        '{7'd37,  8'h2D, 3'd3},  // mask g9 line1
        '{7'd13,  8'h3F, 3'd3},  // g3 level 3
        '{7'd12,  8'h88, 3'd3},  // set g3 line3, tie with g5
        '{7'd20,  8'h01, 3'd3},  // clear g5 line0
        '{7'd12,  8'h08, 3'd7},  // clear g3 line3
        '{7'd121, 8'h0F, 3'd7},  // g30 level 0
        '{7'd120, 8'hF4, 3'd0},  // qualifiers all set, data only line2
        '{7'd121, 8'h7F, 3'd7},  // level 7 never wins
        '{7'd120, 8'h00, 3'd7}   // hold write
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        req_set[idx] = 1'b1;
        @(negedge clk);
        req_set = '0;
    endtask

    task automatic ack(input logic [2:0] l);
        @(negedge clk);
        ack_valid = 1'b1; ack_level = l;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 level", level_out, 7);
        chk("R1 nmi", nmi_pulse, 0);
        chk("R1 ackerr", ack_error, 0);
        rd(7'd20, rv);  chk("R1 g5 byte0", rv, 0);
        rd(7'd21, rv);  chk("R1 g5 byte1", rv, 0);
        rd(7'd0, rv);   chk("R1 g0 byte0", rv, 0);
        rd(7'd124, rv); chk("R1 accepted", rv, 0);

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 13; i++) begin
            wr(TBL[i].a, TBL[i].d);
            @(negedge clk);
            chk($sformatf("R4 R6 row %0d", i), level_out, TBL[i].lv);
        end

        // R2 R3 readback
        rd(7'd36, rv);  chk("R2 g9 byte0", rv, 8'h20);
        rd(7'd37, rv);  chk("R3 g9 byte1", rv, 8'h2D);
        rd(7'd121, rv); chk("R3 g30 byte1", rv, 8'h7F);
        rd(7'd120, rv); chk("R2 g30 byte0", rv, 8'h44);

        // R5 R10 tie between g3 and g5 set by line pulses in one cycle
        @(negedge clk);
        req_set[20] = 1'b1; req_set[12] = 1'b1;
        @(negedge clk);
        req_set = '0;
        chk("R6 level not yet", level_out, 7);
        @(negedge clk);
        chk("R5 level", level_out, 3);
        ack(3'd3);
        chk("R12 no error", ack_error, 0);
        rd(7'd124, rv); chk("R5 R10 accepted g3", rv, 8'h0C);

        // R10 request gone: accepted reads 0
        wr(7'd12, 8'h01);
        rd(7'd124, rv); chk("R10 lost request", rv, 0);
        @(negedge clk);
        ack(3'd5);
        chk("R12 mismatch", ack_error, 1);
        rd(7'd124, rv); chk("R10 accepted g5", rv, 8'h14);
        @(negedge clk);
        chk("R12 clears", ack_error, 0);

        // R11 write to accepted register
        wr(7'd124, 8'hFF);
        rd(7'd124, rv); chk("R11 accepted unchanged", rv, 8'h14);

        // R7 set wins over same-cycle clear
        @(negedge clk);
        req_set[21] = 1'b1; reg_wr = 1'b1; reg_addr = 7'd20; reg_wdata = 8'h02;
        @(negedge clk);
        req_set = '0; reg_wr = 1'b0;
        rd(7'd20, rv); chk("R7 set wins", rv, 8'h33);

        // R8 R9 R13 non-maskable groups
        pulse(1);
        chk("R9 pulse", nmi_pulse, 1);
        rd(7'd0, rv); chk("R8 g0 read", rv, 8'h02);
        @(negedge clk);
        chk("R9 single cycle", nmi_pulse, 0);
        chk("R13 level", level_out, 3);
        wr(7'd3, 8'h0C);
        chk("R9 byte3 pulse", nmi_pulse, 1);
        rd(7'd0, rv); chk("R8 byte3 set", rv, 8'h0E);
        wr(7'd0, 8'h06);
        chk("R9 no pulse on clear", nmi_pulse, 0);
        rd(7'd0, rv); chk("R8 clear", rv, 8'h08);
        wr(7'd3, 8'h00);
        chk("R9 empty byte3", nmi_pulse, 0);
        pulse(6);
        chk("R9 g1 pulse", nmi_pulse, 1);
        rd(7'd4, rv); chk("R8 g1 read", rv, 8'h04);
        rd(7'd1, rv); chk("R8 g0 byte1", rv, 0);
        @(negedge clk);
        chk("R13 level after nmi", level_out, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule